// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address that a synchronous memory uses on each beat of a short burst. At the start of a cycle the caller presents a full base address with the load/advance input low. The block captures that address along with the ordering mode and a select flag. On each later clock with load/advance high, the block forms the next address in the burst internally. Only the two lowest address bits take part in the sequence. The upper bits stay as they were captured, and the sequence wraps after four beats with no carry out of the low field.

The mode input picks the ordering. With mode low the order is linear: the low bits are the base low bits plus the beat count, modulo four. With mode high the order is interleaved: the low bits are the base low bits XOR the beat count. The mode is sampled together with the base address, so it stays fixed for the whole burst. A clock enable freezes the block completely. An advance that follows a deselected load leaves the block idle. A caller that needs no bursts can load a fresh address on every cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: A clock edge with clkEn high and loadN low makes burstAddr equal the baseAddr sampled at that edge, and makes addrValid equal the selIn sampled at that edge.
- R2: With ilvMode low at the load, the low two bits of burstAddr at beat k after the load are (base low bits + k) mod 4. Example: base low 3 gives 3, 0, 1, 2.
- R3: With ilvMode high at the load, the low two bits of burstAddr at beat k are (base low bits XOR k). Example: base low 1 gives 1, 0, 3, 2.
- R4: On an advance, bits above bit 1 of burstAddr never change, including when the low field rolls from 3 to 0.
- R5: The fourth advance after a load returns burstAddr to the loaded base address, and the sequence then repeats.
- R6: A clock edge with clkEn low leaves burstAddr, addrValid and the beat count unchanged, so the burst later resumes at the beat where it stopped.
- R7: While addrValid is low, an advance (clkEn high, loadN high) leaves addrValid low and burstAddr unchanged.
- R8: A change of ilvMode after the load has no effect on the running burst.
- R9: Loading on every cycle (loadN held low) presents each new baseAddr on the cycle after it was given.
- R10: During reset (rstN low) burstAddr is 0 and addrValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable, active high; low freezes all state |
| loadN | input | 1 | Low: load base address; high: advance the burst |
| selIn | input | 1 | Select flag captured at a load; low starts a deselect cycle |
| ilvMode | input | 1 | Ordering captured at a load: 1 interleaved, 0 linear |
| baseAddr | input | ADDR_W | Base address captured at a load |
| burstAddr | output | ADDR_W | Current burst address |
| addrValid | output | 1 | High when the current cycle is selected |

## Verification
The bench starts a linear burst from a base whose low bits are 3. A design that carries into the upper bits on the roll to 0 shows a wrong upper field there. A design that wraps on the wrong beat fails to return to the base on the fourth advance. An interleaved burst from base low 1 catches a design that adds where it should XOR. Mid-burst stalls with the clock enable low would expose a counter that keeps running. A mode flip in the middle of a burst would expose a design that reads the mode live instead of capturing it at the load. Advances after a deselected load, and a long run of back-to-back loads, cover the idle path and the non-burst use. Randomly mixed stimulus then compares every cycle against a reference model in the bench.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } burstStb_t;
endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clkEn,
  input  logic      loadN,
  input  logic      selIn,
  output burstStb_t stb,
  output logic      activeQ
);
  always_comb begin
    stb.load = clkEn && !loadN;
    stb.step = clkEn && loadN && activeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        activeQ <= 1'b0;
    else if (stb.load) activeQ <= selIn;
  end
endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  burstStb_t         stb,
  input  logic              ilvMode,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] burstAddr
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  cntQ;
  logic              modeQ;
  logic [CNT_W-1:0]  lowLin;
  logic [CNT_W-1:0]  lowIlv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
      modeQ <= 1'b0;
    end else if (stb.load) begin
      baseQ <= baseAddr;
      cntQ  <= '0;
      modeQ <= ilvMode;
    end else if (stb.step) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  always_comb begin
    lowLin = baseQ[CNT_W-1:0] + cntQ;
    lowIlv = baseQ[CNT_W-1:0] ^ cntQ;
  end

  generate
    if (UP_W > 0) begin : g_upper
      assign burstAddr = {baseQ[ADDR_W-1:CNT_W], modeQ ? lowIlv : lowLin};
    end else begin : g_lowOnly
      assign burstAddr = modeQ ? lowIlv : lowLin;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              loadN,
  input  logic              selIn,
  input  logic              ilvMode,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] burstAddr,
  output logic              addrValid
);
  burstStb_t stb;

  burst_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .loadN(loadN),
    .selIn(selIn), .stb(stb), .activeQ(addrValid)
  );

  burst_addr_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ilvMode(ilvMode),
    .baseAddr(baseAddr), .burstAddr(burstAddr)
  );
endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
)(
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              loadN,
  input logic              selIn,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [ADDR_W-1:0] burstAddr,
  input logic              addrValid
);
  p_load_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !loadN) |=> (burstAddr == $past(baseAddr)));

  p_load_sel_r1: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !loadN) |=> (addrValid == $past(selIn)));

  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && loadN) |=> (burstAddr[ADDR_W-1:CNT_W] == $past(burstAddr[ADDR_W-1:CNT_W])));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(burstAddr) && $stable(addrValid)));

  p_desel_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && loadN && !addrValid) |=> (!addrValid && $stable(burstAddr)));

  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_r10: assert (burstAddr == '0 && !addrValid);
    end
  end
endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .loadN(loadN), .selIn(selIn),
  .baseAddr(baseAddr), .burstAddr(burstAddr), .addrValid(addrValid)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/100ps
module test_burst_addr_gen;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clkEn = 1'b0;
  logic          loadN = 1'b1;
  logic          selIn = 1'b0;
  logic          ilvMode = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [AW-1:0] burstAddr;
  logic          addrValid;

  int checks = 0;
  int failures = 0;

  logic [AW-1:0] mBase = '0;
  logic [1:0]    mCnt = '0;
  logic          mMode = 1'b0;
  logic          mValid = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) i_burst_addr_gen (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .loadN(loadN), .selIn(selIn),
    .ilvMode(ilvMode), .baseAddr(baseAddr), .burstAddr(burstAddr), .addrValid(addrValid)
  );

  function automatic logic [AW-1:0] expAddr(logic [AW-1:0] b, logic [1:0] c, logic m);
    logic [1:0] lo;
    lo = m ? (b[1:0] ^ c) : (b[1:0] + c);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW:0] act, logic [AW:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic ce, logic ld, logic sel, logic md, logic [AW-1:0] b, string tag);
    clkEn = ce; loadN = ld; selIn = sel; ilvMode = md; baseAddr = b;
    @(posedge clk);
    if (ce) begin
      if (!ld) begin mBase = b; mCnt = '0; mMode = md; mValid = sel; end
      else if (mValid) mCnt = mCnt + 2'd1;
    end
    @(negedge clk);
    check(tag, {addrValid, burstAddr}, {mValid, expAddr(mBase, mCnt, mMode)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [1:0] ilvSeq [4];
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R10", {addrValid, burstAddr}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R2, R4, R5: linear from low bits 3, upper field must not carry
    cyc(1, 0, 1, 0, 17'h1_5A63, "R1");
    check("R2", {15'd0, burstAddr[1:0]}, 17'd3);
    cyc(1, 1, 1, 0, 17'h0, "R4");
    check("R4", {1'b0, burstAddr}, {1'b0, 17'h1_5A60});
    cyc(1, 1, 1, 0, 17'h0, "R2");
    cyc(1, 1, 1, 0, 17'h0, "R2");
    cyc(1, 1, 1, 0, 17'h0, "R5");
    check("R5", {1'b0, burstAddr}, {1'b0, 17'h1_5A63});

    // R3: interleaved from low bits 1 gives 1,0,3,2
    ilvSeq = '{2'd1, 2'd0, 2'd3, 2'd2};
    cyc(1, 0, 1, 1, 17'h0_0F01, "R3");
    for (int k = 0; k < 4; k++) begin
      check("R3", {15'd0, burstAddr[1:0]}, {15'd0, ilvSeq[k]});
      cyc(1, 1, 1, 1, 17'h0, "R3");
    end
    check("R5", {1'b0, burstAddr}, {1'b0, 17'h0_0F01});

    // R6: stall mid burst then resume
    cyc(1, 0, 1, 0, 17'h0_2220, "R1");
    cyc(1, 1, 1, 0, 17'h0, "R6");
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 17'h1_FFFF, "R6");
    cyc(1, 1, 1, 0, 17'h0, "R6");
    check("R6", {1'b0, burstAddr}, {1'b0, 17'h0_2222});

    // R8: mode change mid burst ignored
    cyc(1, 0, 1, 0, 17'h0_1111, "R1");
    cyc(1, 1, 1, 1, 17'h0, "R8");
    cyc(1, 1, 1, 1, 17'h0, "R8");
    check("R8", {1'b0, burstAddr}, {1'b0, 17'h0_1113});

    // R7: deselect then advances
    cyc(1, 0, 0, 0, 17'h0_4442, "R7");
    for (int k = 0; k < 3; k++) cyc(1, 1, 1, 0, 17'h1_0000, "R7");
    check("R7", {addrValid, burstAddr}, {1'b0, 17'h0_4442});

    // R9: load every cycle
    for (int k = 0; k < 8; k++) cyc(1, 0, 1, k[0], AW'(k * 4099 + 7), "R9");

    // Random mix
    for (int k = 0; k < 400; k++) begin
      cyc(($urandom % 5) != 0, ($urandom % 4) != 0, ($urandom % 6) != 0,
          $urandom % 2, AW'($urandom), "R1-mix");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule